// File: doc/BRIEF.md
# Dual-Slope Center-Aligned PWM Timer

This block is a timer/counter that counts up from zero to a programmable TOP value, turns around and counts back down to zero. Two compare channels each drive a pulse-width output from that triangle. Because the count runs up and down, every pulse is centred in its period. The counter moves one step only on clock cycles where the timer-clock strobe is high. A prescaler outside the block produces that strobe.

TOP comes from one of two places, chosen by a select input. It is either the value presented on the capture input or the buffered value of compare channel A. Compare values, TOP and the TOP source are held in shadow registers. They are copied into the active set only at BOTTOM, so the rising and falling slopes of any one period always match. The block gives one-clock flag pulses at BOTTOM, at TOP when the capture input sets TOP, and on every compare match. An interrupt controller outside the block uses these pulses.

Top module: `dual_slope_pwm`

## Requirements
- R1: After reset the count is 0, all flags are 0, and the internal waveform of both channels is low. A pin in output mode 2 therefore reads 0 and a pin in output mode 3 reads 1.
- R2: The count changes only on clock cycles where `tick` is 1. With `tick` held at 0 the count holds its value.
- R3: Each step changes the count by exactly one. It rises from 0 to TOP, stays at TOP for one tick, and falls back to 0. It stays at 0 for one tick, so a period lasts 2*TOP ticks. TOP must be at least 3.
- R4: With `top_src` = 0 (mode 8), TOP is taken from `cap_val`. With `top_src` = 1 (mode 9), TOP is taken from the buffered compare A value.
- R5: A write to a compare buffer, a change of `cap_val` and a change of `top_src` take effect only at the BOTTOM tick. Until then the period in progress keeps its TOP and its compare values.
- R6: `flag_bottom` pulses for one clock on the tick that leaves 0. This is the same tick on which the active values are loaded, so during the pulse the count reads 1.
- R7: In mode 8, `flag_top_cap` pulses for one clock when the count reaches TOP. In mode 9 it stays 0, and `flag_cmp_a` pulses when the count reaches TOP.
- R8: `flag_cmp_a` or `flag_cmp_b` pulses for one clock each time the count takes the channel's active compare value. For a compare value strictly between 0 and TOP, that happens twice per period.
- R9: Output mode 2 (`out_mode_x` = 2'b10) gives a non-inverted waveform. It clears on a match while counting up and sets on a match while counting down, so it is high for 2*C ticks per period, where C is the compare value and 0 < C < TOP. Mode 3 (2'b11) gives the inverse, high for 2*(TOP-C) ticks. Modes 0 and 1 hold the pin at 0.
- R10: A channel whose compare value is above TOP never matches. Its flag stays 0 and its pin does not change.
- R11: The count is 16 bits wide. With TOP = 16'hFFFF the counter reaches 16'hFFFF and then turns to 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer-clock enable strobe |
| top_src | input | 1 | TOP source: 0 = capture value (mode 8), 1 = compare A (mode 9) |
| cap_val | input | 16 | Input-capture register value |
| cmp_a_wr | input | 1 | Write strobe for the compare A buffer |
| cmp_a_din | input | 16 | Data for the compare A buffer |
| cmp_b_wr | input | 1 | Write strobe for the compare B buffer |
| cmp_b_din | input | 16 | Data for the compare B buffer |
| out_mode_a | input | 2 | Output mode of pin A |
| out_mode_b | input | 2 | Output mode of pin B |
| cnt | output | 16 | Current count |
| pwm_a | output | 1 | Waveform output A |
| pwm_b | output | 1 | Waveform output B |
| flag_bottom | output | 1 | BOTTOM pulse, coincides with the buffer transfer |
| flag_top_cap | output | 1 | TOP pulse when TOP comes from the capture value |
| flag_cmp_a | output | 1 | Compare A match pulse |
| flag_cmp_b | output | 1 | Compare B match pulse |

## Verification
The assertions check on every cycle that the counter holds without a strobe and moves by exactly one step with it. They also check that it never passes TOP, that the active TOP and compare values change only together with the BOTTOM pulse, and that each flag pulse coincides with the count value it reports. Only the bench scenarios can show the duty cycle of each output polarity, the mid-period writes that must wait for the next period, the switch of TOP source, the suppressed matches for a compare value above TOP and the full 16-bit turnaround.

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         top_src,
  input  logic [W-1:0] cap_val,
  input  logic         cmp_a_wr,
  input  logic [W-1:0] cmp_a_din,
  input  logic         cmp_b_wr,
  input  logic [W-1:0] cmp_b_din,
  input  logic [1:0]   out_mode_a,
  input  logic [1:0]   out_mode_b,
  output logic [W-1:0] cnt,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         flag_bottom,
  output logic         flag_top_cap,
  output logic         flag_cmp_a,
  output logic         flag_cmp_b
);

  logic         down, src_act, wave_a, wave_b;
  logic [W-1:0] top_act, buf_a, buf_b, act_a, act_b;

  wire          at_bottom = tick && (cnt == '0);
  wire          at_top    = tick && !at_bottom && !down && (cnt == top_act);

  wire          src_nxt = at_bottom ? top_src : src_act;
  wire [W-1:0]  top_nxt = at_bottom ? (top_src ? buf_a : cap_val) : top_act;
  wire [W-1:0]  a_nxt   = at_bottom ? buf_a : act_a;
  wire [W-1:0]  b_nxt   = at_bottom ? buf_b : act_b;
  wire          dn_nxt  = at_bottom ? 1'b0 : (at_top ? 1'b1 : down);
  wire [W-1:0]  cnt_nxt = dn_nxt ? cnt - W'(1) : cnt + W'(1);

  assign pwm_a = out_mode_a[1] & (wave_a ^ out_mode_a[0]);
  assign pwm_b = out_mode_b[1] & (wave_b ^ out_mode_b[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_a <= '0;
      buf_b <= '0;
    end else begin
      if (cmp_a_wr) buf_a <= cmp_a_din;
      if (cmp_b_wr) buf_b <= cmp_b_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      down         <= 1'b0;
      src_act      <= 1'b0;
      top_act      <= '0;
      act_a        <= '0;
      act_b        <= '0;
      wave_a       <= 1'b0;
      wave_b       <= 1'b0;
      flag_bottom  <= 1'b0;
      flag_top_cap <= 1'b0;
      flag_cmp_a   <= 1'b0;
      flag_cmp_b   <= 1'b0;
    end else begin
      flag_bottom  <= 1'b0;
      flag_top_cap <= 1'b0;
      flag_cmp_a   <= 1'b0;
      flag_cmp_b   <= 1'b0;
      if (tick) begin
        cnt          <= cnt_nxt;
        down         <= dn_nxt;
        src_act      <= src_nxt;
        top_act      <= top_nxt;
        act_a        <= a_nxt;
        act_b        <= b_nxt;
        flag_bottom  <= at_bottom;
        flag_top_cap <= !src_nxt && !dn_nxt && (cnt_nxt == top_nxt);
        flag_cmp_a   <= (cnt_nxt == a_nxt);
        flag_cmp_b   <= (cnt_nxt == b_nxt);
        if (cnt_nxt == a_nxt) wave_a <= dn_nxt;
        if (cnt_nxt == b_nxt) wave_b <= dn_nxt;
      end
    end
  end

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == W'($past(cnt) + W'(1))) || (cnt == W'($past(cnt) - W'(1))));

  assert_below_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (top_act >= W'(3)) |-> (cnt <= top_act));

  assert_load_at_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_bottom |-> ($stable(top_act) && $stable(act_a) && $stable(act_b)));

  assert_bottom_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_bottom |-> (cnt == W'(1)) && ($past(cnt) == '0));

  assert_top_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_top_cap |-> (cnt == top_act) && !down && !src_act);

  assert_cmp_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_cmp_a |-> (cnt == act_a));

endmodule

// File: tb/dual_slope_pwm_tb.sv
module dual_slope_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n, tick, top_src, cmp_a_wr, cmp_b_wr;
  logic [15:0] cap_val, cmp_a_din, cmp_b_din;
  logic [1:0]  out_mode_a, out_mode_b;
  logic [15:0] cnt;
  logic        pwm_a, pwm_b, flag_bottom, flag_top_cap, flag_cmp_a, flag_cmp_b;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_slope_pwm #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_src(top_src), .cap_val(cap_val),
    .cmp_a_wr(cmp_a_wr), .cmp_a_din(cmp_a_din), .cmp_b_wr(cmp_b_wr), .cmp_b_din(cmp_b_din),
    .out_mode_a(out_mode_a), .out_mode_b(out_mode_b), .cnt(cnt), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .flag_bottom(flag_bottom), .flag_top_cap(flag_top_cap),
    .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b));

  // {top, cmp A, cmp B, high ticks of A (mode 2), high ticks of B (mode 3)}
  localparam logic [79:0] VEC [6] = '{
    {16'd10, 16'd3,  16'd7,  16'd6,  16'd6},
    {16'd10, 16'd1,  16'd9,  16'd2,  16'd2},
    {16'd20, 16'd10, 16'd5,  16'd20, 16'd30},
    {16'd5,  16'd2,  16'd4,  16'd4,  16'd2},
    {16'd40, 16'd39, 16'd1,  16'd78, 16'd78},
    {16'd3,  16'd1,  16'd2,  16'd2,  16'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [15:0] v);
    @(negedge clk); cmp_a_wr = 1'b1; cmp_a_din = v;
    @(negedge clk); cmp_a_wr = 1'b0;
  endtask

  task automatic wr_b(input logic [15:0] v);
    @(negedge clk); cmp_b_wr = 1'b1; cmp_b_din = v;
    @(negedge clk); cmp_b_wr = 1'b0;
  endtask

  task automatic wait_bottom();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (flag_bottom) return;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; top_src = 1'b0; cap_val = 16'd10;
    cmp_a_wr = 1'b0; cmp_b_wr = 1'b0; cmp_a_din = '0; cmp_b_din = '0;
    out_mode_a = 2'b10; out_mode_b = 2'b11;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt == 0, "R1 count", cnt, 0);
    chk({flag_bottom, flag_top_cap, flag_cmp_a, flag_cmp_b} == 4'b0, "R1 flags", 0, 0);
    chk(pwm_a == 1'b0 && pwm_b == 1'b1, "R1 pins", {pwm_a, pwm_b}, 1);

    // R2 no tick, no movement
    begin
      int moved = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (cnt != 0) moved++;
      end
      chk(moved == 0, "R2 hold without tick", moved, 0);
    end

    // table of duty-cycle vectors, mode 8
    tick = 1'b1;
    for (int v = 0; v < 6; v++) begin
      int top, ca, cb, hia, hib, nb, nt, nca, ncb, badb;
      top = int'(VEC[v][79:64]); ca = int'(VEC[v][63:48]); cb = int'(VEC[v][47:32]);
      cap_val = VEC[v][79:64];
      wr_a(VEC[v][63:48]);
      wr_b(VEC[v][47:32]);
      repeat (300) @(negedge clk);
      hia = 0; hib = 0; nb = 0; nt = 0; nca = 0; ncb = 0; badb = 0;
      for (int i = 0; i < 2 * top; i++) begin
        @(negedge clk);
        hia += int'(pwm_a); hib += int'(pwm_b);
        nb += int'(flag_bottom); nt += int'(flag_top_cap);
        nca += int'(flag_cmp_a); ncb += int'(flag_cmp_b);
        if (flag_bottom && cnt != 16'd1) badb++;
      end
      chk(hia == int'(VEC[v][31:16]), "R9 mode2 high ticks", hia, int'(VEC[v][31:16]));
      chk(hib == int'(VEC[v][15:0]), "R9 mode3 high ticks", hib, int'(VEC[v][15:0]));
      chk(nb == 1 && badb == 0, "R6 bottom pulse per period", nb, 1);
      chk(nt == 1, "R7 top pulse per period (R4 cap source)", nt, 1);
      chk(nca == 2, "R8 cmp A matches", nca, 2);
      chk(ncb == 2, "R8 cmp B matches", ncb, 2);
      if (ca < 0 || cb < 0) $display("unreachable");
    end

    // R3 exact triangle with TOP = 5
    cap_val = 16'd5;
    repeat (50) @(negedge clk);
    wait_bottom();
    begin
      int seq [10] = '{2, 3, 4, 5, 4, 3, 2, 1, 0, 1};
      int bad = -1, got = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (bad < 0 && int'(cnt) != seq[i]) begin bad = i; got = int'(cnt); end
      end
      chk(bad < 0, "R3 count sequence", got, (bad < 0) ? 0 : seq[bad]);
    end

    // R5 mid-period writes wait for BOTTOM
    cap_val = 16'd10;
    wr_a(16'd3);
    repeat (80) @(negedge clk);
    wait_bottom();
    repeat (2) @(negedge clk);
    cap_val = 16'd12;
    cmp_a_wr = 1'b1; cmp_a_din = 16'd6;
    @(negedge clk); cmp_a_wr = 1'b0;
    begin
      int mx = int'(cnt), badm = 0, nm = 0;
      for (int i = 0; i < 200 && !flag_bottom; i++) begin
        @(negedge clk);
        if (int'(cnt) > mx) mx = int'(cnt);
        if (flag_cmp_a) begin nm++; if (cnt != 16'd3) badm++; end
      end
      chk(mx == 10, "R5 old TOP kept", mx, 10);
      chk(nm >= 1 && badm == 0, "R5 old compare kept", badm, 0);
      mx = 0; badm = 0; nm = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (flag_bottom) break;
        if (int'(cnt) > mx) mx = int'(cnt);
        if (flag_cmp_a) begin nm++; if (cnt != 16'd6) badm++; end
      end
      chk(mx == 12, "R5 new TOP after bottom", mx, 12);
      chk(nm == 2 && badm == 0, "R5 new compare after bottom", nm, 2);
    end

    // R4 / R7 mode 9: TOP from compare A
    top_src = 1'b1; cap_val = 16'd30;
    wr_a(16'd8);
    repeat (100) @(negedge clk);
    begin
      int mx = 0, nt = 0, nca = 0, badc = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (int'(cnt) > mx) mx = int'(cnt);
        nt += int'(flag_top_cap);
        if (flag_cmp_a) begin nca++; if (cnt != 16'd8) badc++; end
      end
      chk(mx == 8, "R4 mode 9 TOP from cmp A", mx, 8);
      chk(nt == 0, "R7 no capture flag in mode 9", nt, 0);
      chk(nca == 1 && badc == 0, "R7 cmp A flag at TOP", nca, 1);
    end

    // R10 compare above TOP
    top_src = 1'b0; cap_val = 16'd10;
    wr_b(16'd50);
    repeat (100) @(negedge clk);
    begin
      int ncb = 0, chg = 0;
      logic first = pwm_b;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        ncb += int'(flag_cmp_b);
        if (pwm_b != first) chg++;
      end
      chk(ncb == 0, "R10 no match above TOP", ncb, 0);
      chk(chg == 0, "R10 pin stays", chg, 0);
    end

    // R9 modes 0 and 1 hold pins low
    wr_a(16'd4); wr_b(16'd6);
    out_mode_a = 2'b00; out_mode_b = 2'b01;
    begin
      int hi = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        hi += int'(pwm_a) + int'(pwm_b);
      end
      chk(hi == 0, "R9 disconnected modes low", hi, 0);
    end
    out_mode_a = 2'b10; out_mode_b = 2'b11;

    // R11 full 16-bit TOP
    cap_val = 16'hFFFF;
    wait_bottom();
    begin
      bit hit = 0;
      for (int i = 0; i < 70000; i++) begin
        @(negedge clk);
        if (cnt == 16'hFFFF) begin hit = 1; break; end
      end
      chk(hit, "R11 reaches 16'hFFFF", int'(cnt), 65535);
      chk(flag_top_cap == 1'b1, "R11 top flag at 16'hFFFF", flag_top_cap, 1);
      @(negedge clk);
      chk(cnt == 16'hFFFE, "R11 turns down", int'(cnt), 65534);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule